// File: doc/BRIEF.md
# Vectored nested priority interrupt controller

This block gathers a set of interrupt inputs and presents one active-low request line to a processor. Each input can be programmed as rising-edge or level sensitive, and each has a priority and a vector word of its own. When the processor takes the request it accesses the vector register over a simple register bus. That access picks the best pending source and returns its vector word. It also records the level it left on an internal stack, raises the current level to that source's priority and acknowledges the source. The request line then falls silent until something more urgent arrives, and this is how handlers nest.

A write to the end-of-interrupt register pops the stack and restores the level that was interrupted. In protect mode a read of the vector register has no side effects at all, so a debugger can inspect it freely. The step that commits the interrupt moves to a following write of the same register. When no source qualifies, the access returns a programmable spurious word and changes nothing.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the request line `irq_n` is high, every source is disabled (enable mask reads 0 at address 66), the mode reads 0 (normal) at address 70, and no interrupt is current. While the enable mask is zero, `irq_n` stays high.
- R2: A vector-register access selects, among sources that are pending and enabled and whose priority is strictly above the current level, the one with the highest priority, with the lowest source number winning a tie. When no interrupt is current, priority 0 counts as above the current level.
- R3: Reading the vector register (address 64) returns the 32-bit vector word of the selected source. If no source qualifies it returns the spurious word (address 69) and leaves the stack and the current level unchanged.
- R4: In normal mode (address 70 bit 0 = 0) a read of address 64 commits the selection: the previous level is pushed, the current level becomes the selected priority, and the source is acknowledged. A write to address 64 in normal mode has no effect.
- R5: In protect mode (address 70 bit 0 = 1) a read of address 64 returns the vector without any side effect. A write to address 64 commits the source that qualifies at that write.
- R6: `irq_n` is low exactly when some pending enabled source has a priority strictly above the current level. This holds during handlers too, so that nesting works.
- R7: An edge source becomes pending one clock after its input is first sampled high following a low sample, and its pending flag is cleared by its acknowledge. A level source is pending one clock after its input is sampled high and stays pending while the input is high, even after it is acknowledged.
- R8: A write to address 65 pops the stack and restores the previous current level. With an empty stack it is ignored. Eight nested acknowledges fit on the stack.
- R9: A write to address 66 sets enable bits, and a write to address 67 clears them (1 bits act). A write to address 68 makes the marked sources pending until they are acknowledged. A disabled source keeps its pending state but is never selected.
- R10: Address n (0 to 31) holds source n's configuration: bits [2:0] are the priority and bit 4 is the edge mode. Address 32+n holds source n's vector word. Both read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Interrupt source inputs |
| bus_addr | input | 7 | Register word address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
Single edge pulses separate edge capture and automatic clearing from the level behaviour. Inputs held high show that a level source returns after its handler ends. Staggered arrivals at rising, equal and falling priorities while a handler runs show whether only strictly higher levels re-raise the request, and whether the end-of-interrupt pops restore each level in order. Two equal-priority sources set together test the tie order. A ladder of eight priorities tests full stack depth and a pop on the empty stack. Long runs of random inputs and bus operations in both modes are followed against a behavioural model on every clock, which exposes wrong side effects of reads and writes.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
    // offsets of the control registers above the configuration and vector banks
    typedef enum logic [2:0] {
        CTL_VECTOR = 3'd0,
        CTL_EOI    = 3'd1,
        CTL_ENSET  = 3'd2,
        CTL_ENCLR  = 3'd3,
        CTL_SWSET  = 3'd4,
        CTL_SPUR   = 3'd5,
        CTL_MODE   = 3'd6
    } ctl_e;
endpackage

// File: rtl/nest_irq_sense.sv
module nest_irq_sense #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [NSRC-1:0] edge_mode,
    input  logic [NSRC-1:0] sw_set,
    input  logic [NSRC-1:0] ack_vec,
    output logic [NSRC-1:0] pend
);
    typedef struct packed {
        logic [NSRC-1:0] prev;
        logic [NSRC-1:0] lvl;
        logic [NSRC-1:0] epend;
        logic [NSRC-1:0] swp;
    } sense_t;

    sense_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.prev  = src_in;
        s_d.lvl   = src_in;
        // a fresh edge or software set wins over a same-cycle acknowledge
        s_d.epend = (s_q.epend & ~ack_vec) | (src_in & ~s_q.prev) | sw_set;
        s_d.swp   = (s_q.swp | sw_set) & ~ack_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_pend
            assign pend[g] = edge_mode[g] ? s_q.epend[g] : (s_q.lvl[g] | s_q.swp[g]);
        end
    endgenerate
endmodule

// File: rtl/nest_irq_pick.sv
module nest_irq_pick #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    parameter int IW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]         cand_in,
    input  logic [NSRC-1:0][PW-1:0] prio,
    input  logic [PW:0]             floor_rank,
    output logic                    hit,
    output logic [IW-1:0]           idx
);
    logic [NSRC-1:0] above;
    logic [PW-1:0]   best;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_above
            // rank 0 means idle; rank p+1 means level p is current
            assign above[g] = ({1'b0, prio[g]} + 1'b1) > floor_rank;
        end
    endgenerate

    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (cand_in[i] && above[i] && (!hit || prio[i] > best)) begin
                hit  = 1'b1;
                idx  = IW'(i);
                best = prio[i];
            end
        end
    end
endmodule

// File: rtl/nest_irq_stack.sv
module nest_irq_stack #(
    parameter int DEPTH = 8,
    parameter int RW    = 4,
    parameter int SW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [RW-1:0] push_rank,
    output logic [RW-1:0] cur_rank,
    output logic [SW-1:0] depth
);
    typedef struct packed {
        logic [DEPTH-1:0][RW-1:0] mem;
        logic [SW-1:0]            sp;
        logic [RW-1:0]            cur;
    } stk_t;

    stk_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (push && k_q.sp != SW'(DEPTH)) begin
            k_d.mem[k_q.sp[SW-2:0]] = k_q.cur;
            k_d.cur                 = push_rank;
            k_d.sp                  = k_q.sp + 1'b1;
        end else if (pop && k_q.sp != '0) begin
            k_d.cur = k_q.mem[k_q.sp[SW-2:0] - 1'b1];
            k_d.sp  = k_q.sp - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign cur_rank = k_q.cur;
    assign depth    = k_q.sp;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
    parameter int NSRC = 32,
    parameter int PW   = 3,
    parameter int VW   = 32,
    parameter int AW   = $clog2(2 * NSRC + 8)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_in,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [VW-1:0]   bus_wdata,
    output logic [VW-1:0]   bus_rdata,
    output logic            irq_n
);
    import nest_irq_pkg::*;

    localparam int IW       = $clog2(NSRC);
    localparam int RW       = PW + 1;
    localparam int DEPTH    = 2 ** PW;
    localparam int SW       = $clog2(DEPTH + 1);
    localparam int EDGE_BIT = PW + 1;
    localparam logic [AW-1:0] VEC_BASE = AW'(NSRC);
    localparam logic [AW-1:0] CTL_BASE = AW'(2 * NSRC);
    localparam logic [AW-1:0] VEC_ADDR = CTL_BASE + AW'(CTL_VECTOR);
    localparam logic [AW-1:0] EOI_ADDR = CTL_BASE + AW'(CTL_EOI);

    typedef struct packed {
        logic [NSRC-1:0][PW-1:0] prio;
        logic [NSRC-1:0]         edg;
        logic [NSRC-1:0][VW-1:0] vec;
        logic [NSRC-1:0]         en;
        logic [VW-1:0]           spur;
        logic                    mode;
    } regs_t;

    regs_t r_d, r_q;

    logic            mode_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] sw_set;
    logic [NSRC-1:0] ack_vec;
    logic            hit;
    logic [IW-1:0]   pick;
    logic [RW-1:0]   cur_rank;
    logic [SW-1:0]   stk_depth;
    logic            do_ack;
    logic            do_pop;
    logic            is_cfg, is_vec, is_ctl;
    logic [IW-1:0]   cidx, vidx;
    logic [2:0]      coff;

    assign mode_q = r_q.mode;
    assign en_q   = r_q.en;

    // address decode
    always_comb begin
        is_cfg = bus_addr < VEC_BASE;
        is_vec = (bus_addr >= VEC_BASE) && (bus_addr < CTL_BASE);
        is_ctl = (bus_addr >= CTL_BASE) && (bus_addr < CTL_BASE + AW'(8));
        cidx   = bus_addr[IW-1:0];
        vidx   = IW'(bus_addr - VEC_BASE);
        coff   = 3'(bus_addr - CTL_BASE);
    end

    // register file next state and commit decisions
    always_comb begin
        r_d     = r_q;
        sw_set  = '0;
        do_pop  = 1'b0;
        do_ack  = 1'b0;
        ack_vec = '0;
        if (bus_rd && bus_addr == VEC_ADDR && !mode_q) do_ack = hit;
        if (bus_wr && bus_addr == VEC_ADDR &&  mode_q) do_ack = hit;
        if (do_ack) ack_vec[pick] = 1'b1;
        if (bus_wr) begin
            if (is_cfg) begin
                r_d.prio[cidx] = bus_wdata[PW-1:0];
                r_d.edg[cidx]  = bus_wdata[EDGE_BIT];
            end else if (is_vec) begin
                r_d.vec[vidx] = bus_wdata;
            end else if (is_ctl) begin
                case (coff)
                    CTL_EOI:   do_pop = 1'b1;
                    CTL_ENSET: r_d.en = r_q.en | bus_wdata[NSRC-1:0];
                    CTL_ENCLR: r_d.en = r_q.en & ~bus_wdata[NSRC-1:0];
                    CTL_SWSET: sw_set = bus_wdata[NSRC-1:0];
                    CTL_SPUR:  r_d.spur = bus_wdata;
                    CTL_MODE:  r_d.mode = bus_wdata[0];
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read path, valid in the cycle of the strobe
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (is_cfg) begin
                bus_rdata[PW-1:0]     = r_q.prio[cidx];
                bus_rdata[EDGE_BIT]   = r_q.edg[cidx];
            end else if (is_vec) begin
                bus_rdata = r_q.vec[vidx];
            end else if (is_ctl) begin
                case (coff)
                    CTL_VECTOR: bus_rdata = hit ? r_q.vec[pick] : r_q.spur;
                    CTL_ENSET:  bus_rdata[NSRC-1:0] = r_q.en;
                    CTL_SPUR:   bus_rdata = r_q.spur;
                    CTL_MODE:   bus_rdata[0] = mode_q;
                    default:    ;
                endcase
            end
        end
    end

    nest_irq_sense #(.NSRC(NSRC)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .edge_mode (r_q.edg),
        .sw_set    (sw_set),
        .ack_vec   (ack_vec),
        .pend      (pend)
    );

    nest_irq_pick #(.NSRC(NSRC), .PW(PW), .IW(IW)) u_pick (
        .cand_in    (pend & en_q),
        .prio       (r_q.prio),
        .floor_rank (cur_rank),
        .hit        (hit),
        .idx        (pick)
    );

    nest_irq_stack #(.DEPTH(DEPTH), .RW(RW), .SW(SW)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_ack),
        .pop       (do_pop),
        .push_rank ({1'b0, r_q.prio[pick]} + 1'b1),
        .cur_rank  (cur_rank),
        .depth     (stk_depth)
    );

    assign irq_n = ~hit;
endmodule

module nest_irq_chk #(
    parameter int NSRC  = 32,
    parameter int AW    = 7,
    parameter int RW    = 4,
    parameter int SW    = 4,
    parameter int DEPTH = 8,
    parameter logic [AW-1:0] VEC_ADDR = '0,
    parameter logic [AW-1:0] EOI_ADDR = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic            irq_n,
    input logic            mode_q,
    input logic [NSRC-1:0] en_q,
    input logic [SW-1:0]   stk_depth,
    input logic [RW-1:0]   cur_rank
);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_depth <= SW'(DEPTH));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == EOI_ADDR && stk_depth == '0) |=> (stk_depth == '0 && cur_rank == '0));

    // R5
    protect_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && bus_rd && bus_addr == VEC_ADDR) |=> ($stable(cur_rank) && $stable(stk_depth)));

    // R4
    normal_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && bus_wr && bus_addr == VEC_ADDR) |=> ($stable(cur_rank) && $stable(stk_depth)));

    // R2
    push_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_depth > $past(stk_depth)) |-> (cur_rank > $past(cur_rank)));

    // R1
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> irq_n);
endmodule

bind nest_irq_ctrl nest_irq_chk #(
    .NSRC(NSRC), .AW(AW), .RW(RW), .SW(SW), .DEPTH(DEPTH),
    .VEC_ADDR(VEC_ADDR), .EOI_ADDR(EOI_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .irq_n     (irq_n),
    .mode_q    (mode_q),
    .en_q      (en_q),
    .stk_depth (stk_depth),
    .cur_rank  (cur_rank)
);

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;
    localparam int NS = 32;
    localparam logic [6:0] A_VEC = 7'd64, A_EOI = 7'd65, A_ENS = 7'd66, A_ENC = 7'd67,
                           A_SWS = 7'd68, A_SPR = 7'd69, A_MOD = 7'd70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    nest_irq_ctrl u_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    // behavioural reference state
    int          m_prio [NS];
    bit          m_edge [NS];
    logic [31:0] m_vec  [NS];
    bit   [31:0] m_en, m_ep, m_swp, m_lvl, m_prev;
    bit          m_mode;
    logic [31:0] m_spur;
    int          m_cur;
    int          m_stk[$];

    function automatic bit m_pend(int i);
        return m_edge[i] ? m_ep[i] : (m_lvl[i] | m_swp[i]);
    endfunction

    function automatic int m_best();
        int b = -1;
        for (int i = 0; i < NS; i++)
            if (m_en[i] && m_pend(i) && m_prio[i] > m_cur)
                if (b < 0 || m_prio[i] > m_prio[b]) b = i;
        return b;
    endfunction

    function automatic logic [31:0] m_read(logic [6:0] a);
        int b;
        logic [31:0] v = '0;
        if (a < 32) begin v[2:0] = 3'(m_prio[a]); v[4] = m_edge[a]; end
        else if (a < 64) v = m_vec[a - 32];
        else if (a == A_VEC) begin b = m_best(); v = (b >= 0) ? m_vec[b] : m_spur; end
        else if (a == A_ENS) v = m_en;
        else if (a == A_SPR) v = m_spur;
        else if (a == A_MOD) v = {31'd0, m_mode};
        return v;
    endfunction

    always @(posedge clk) begin : model
        int s;
        bit [31:0] ackv, sw;
        ackv = '0; sw = '0;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin m_prio[i] = 0; m_edge[i] = 0; m_vec[i] = '0; end
            m_en = '0; m_ep = '0; m_swp = '0; m_lvl = '0; m_prev = '0;
            m_mode = 0; m_spur = '0; m_cur = -1; m_stk.delete();
        end else begin
            s = m_best();
            if (s >= 0 && ((bus_rd && bus_addr == A_VEC && !m_mode) ||
                           (bus_wr && bus_addr == A_VEC && m_mode))) begin
                m_stk.push_back(m_cur); m_cur = m_prio[s]; ackv[s] = 1'b1;
            end
            if (bus_wr) begin
                if (bus_addr < 32) begin
                    m_prio[bus_addr] = int'(bus_wdata[2:0]); m_edge[bus_addr] = bus_wdata[4];
                end else if (bus_addr < 64) m_vec[bus_addr - 32] = bus_wdata;
                else if (bus_addr == A_EOI) begin
                    if (m_stk.size() > 0) m_cur = m_stk.pop_back();
                end
                else if (bus_addr == A_ENS) m_en = m_en | bus_wdata;
                else if (bus_addr == A_ENC) m_en = m_en & ~bus_wdata;
                else if (bus_addr == A_SWS) sw = bus_wdata;
                else if (bus_addr == A_SPR) m_spur = bus_wdata;
                else if (bus_addr == A_MOD) m_mode = bus_wdata[0];
            end
            m_ep   = (m_ep & ~ackv) | (src_in & ~m_prev) | sw;
            m_swp  = (m_swp | sw) & ~ackv;
            m_lvl  = src_in;
            m_prev = src_in;
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model one ns before each rising edge
    always @(negedge clk) begin
        #3;
        if (rst_n && !done) begin
            chk(irq_n === (m_best() < 0), {cur_tag, " irq_n"}, {31'd0, irq_n}, {31'd0, m_best() < 0});
            if (bus_rd) chk(bus_rdata === m_read(bus_addr), {cur_tag, " rdata"}, bus_rdata, m_read(bus_addr));
        end
    end

    task automatic op(logic [6:0] a, bit w, bit r, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d); op(a, 1'b1, 1'b0, d); endtask
    task automatic rd(logic [6:0] a);                 op(a, 1'b0, 1'b1, '0); endtask
    task automatic idle(int n); repeat (n) @(negedge clk); endtask
    task automatic drive(logic [31:0] v); @(negedge clk); src_in = v; endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #3;
        cur_tag = "R1";
        chk(irq_n === 1'b1, "R1 reset irq_n", {31'd0, irq_n}, 32'd1);
        rd(A_ENS); rd(A_MOD);

        // configuration and readback
        cur_tag = "R10";
        wr(7'd3,  32'h12); wr(7'd5,  32'h02); wr(7'd9,  32'h16); wr(7'd12, 32'h00);
        wr(7'd20, 32'h16);
        for (int k = 0; k < 8; k++) wr(7'(24 + k), 32'h10 | k);
        for (int k = 0; k < NS; k++) wr(7'(32 + k), 32'hA000_0000 + k);
        wr(A_SPR, 32'hDEAD_BEEF);
        rd(7'd3); rd(7'd9); rd(7'(32 + 9)); rd(A_SPR);

        // pending while disabled stays quiet
        cur_tag = "R9";
        drive(32'h8); drive(32'h0); idle(2);
        chk(irq_n === 1'b1, "R9 disabled source quiet", {31'd0, irq_n}, 32'd1);
        wr(A_ENS, 32'hFFFF_FFFF); idle(1); rd(A_ENS);

        // edge pending taken, spurious afterwards
        cur_tag = "R3";
        rd(A_VEC); idle(1); rd(A_VEC); wr(A_EOI, 0); idle(1);

        cur_tag = "R7";
        drive(32'h8); drive(32'h0); idle(1); rd(A_VEC); idle(1); wr(A_EOI, 0); idle(2);

        // nesting with a level source
        cur_tag = "R6";
        drive(32'h20); idle(1); rd(A_VEC); idle(1);
        drive(32'h220); drive(32'h20); idle(1); rd(A_VEC); idle(1);
        drive(32'h0010_0020); drive(32'h20); idle(2);
        cur_tag = "R8";
        wr(A_EOI, 0); idle(1); rd(A_VEC); idle(1);
        wr(A_EOI, 0); wr(A_EOI, 0); idle(2);
        cur_tag = "R7";
        rd(A_VEC); idle(1); wr(A_EOI, 0); drive(32'h0); idle(2);

        // equal priorities: lowest number wins
        cur_tag = "R2";
        wr(A_SWS, 32'h0010_0200); idle(1); rd(A_VEC); idle(1); rd(A_VEC);
        wr(A_EOI, 0); wr(A_EOI, 0); idle(1);
        drive(32'h1000); idle(1); rd(A_VEC); wr(A_EOI, 0); drive(32'h0); idle(2);

        // write to the vector register ignored in normal mode
        cur_tag = "R4";
        wr(A_SWS, 32'h8); idle(1); wr(A_VEC, 0); idle(1);
        chk(irq_n === 1'b0, "R4 normal write ignored", {31'd0, irq_n}, 32'd0);
        rd(A_VEC); idle(1); wr(A_EOI, 0);

        // protect mode
        cur_tag = "R5";
        wr(A_MOD, 1); rd(A_MOD);
        wr(A_SWS, 32'h8); idle(1); rd(A_VEC); rd(A_VEC); idle(1);
        chk(irq_n === 1'b0, "R5 read has no side effect", {31'd0, irq_n}, 32'd0);
        wr(A_VEC, 0); idle(1);
        chk(irq_n === 1'b1, "R5 write commits", {31'd0, irq_n}, 32'd1);
        wr(A_EOI, 0); wr(A_VEC, 0); rd(A_VEC); wr(A_MOD, 0); idle(1);

        // full ladder of eight levels, then pops including one on empty stack
        cur_tag = "R8";
        for (int k = 0; k < 8; k++) begin
            wr(A_SWS, 32'(1) << (24 + k)); idle(1); rd(A_VEC);
        end
        wr(A_SWS, 32'h0100_0000); idle(1);
        for (int k = 0; k < 9; k++) begin wr(A_EOI, 0); idle(1); end
        rd(A_VEC); for (int k = 0; k < 3; k++) wr(A_EOI, 0);

        // disable then re-enable keeps the pending state
        cur_tag = "R9";
        wr(A_ENC, 32'h200); drive(32'h200); drive(32'h0); idle(2);
        wr(A_ENS, 32'h200); idle(1); rd(A_VEC); wr(A_EOI, 0); idle(1);

        // random traffic in both modes
        for (int ph = 0; ph < 2; ph++) begin
            cur_tag = (ph == 0) ? "R6" : "R5";
            wr(A_MOD, ph);
            for (int n = 0; n < 3000; n++) begin
                int c;
                c = $urandom_range(0, 9);
                if ($urandom_range(0, 3) == 0) src_in ^= 32'(1) << $urandom_range(0, NS - 1);
                case (c)
                    0, 1: rd(A_VEC);
                    2:    wr(A_VEC, 0);
                    3, 4: wr(A_EOI, 0);
                    5:    wr(A_SWS, 32'(1) << $urandom_range(0, NS - 1));
                    6:    wr(A_ENC, 32'(1) << $urandom_range(0, NS - 1));
                    7:    wr(A_ENS, $urandom());
                    default: idle(1);
                endcase
            end
        end
        idle(2);
        finish_run();
    end
endmodule